// File: doc/BRIEF.md
# Per-Device DQ Select Driver

This block picks which DRAM devices on a DDR4 rank accept a mode-register-set command. It does this by pulling the DQ lanes of each device low or leaving them high while the command is in flight. It keeps a mask with one enable per DQ nibble. A sequencer programs that mask one device at a time, or sets all of it in one cycle. Select is active low: an enable of 0 picks the device and an enable of 1 leaves it out.

The command path pulses a strobe when it issues the MRS. If the function-enable bit is set and no earlier window is still running, the block waits a programmable number of start cycles. It then drives the mask onto the nibble select outputs for a programmable hold time. After that it returns every nibble to the idle high level and gives a one-cycle done pulse.

Device indices map to nibbles according to the configured device width. An x4 device owns one nibble. An x8 device owns two adjacent nibbles, and both change in the same write. Enables are laid out in words of four nibbles, so 18 nibbles take five words.

Top module: `dram_dq_select`

## Requirements
- R1: After reset every `dq_sel` bit is 1 and `done` and `idx_err` are 0. The mask resets to all 1s, so no device is selected.
- R2: While no select window is active, every `dq_sel` bit is 1. While the window is active, `dq_sel` equals the enable mask bit for bit, where 0 means the nibble is driven low (device selected).
- R3: With `x8_mode`=0, a write with `wr_idx`=i (0..17) sets only nibble i to `wr_val`.
- R4: With `x8_mode`=1, a write with `wr_idx`=i (0..8) sets nibbles 2i and 2i+1 to `wr_val` in the same cycle.
- R5: A write whose index is at or above the device count (18 for x4, 9 for x8) leaves the mask unchanged. It raises `idx_err` for exactly the cycle after the write.
- R6: `bulk_en` sets every enable to `bulk_val` in one cycle. It takes precedence over a single write in the same cycle, and that single write raises no error.
- R7: With `mode_en`=0, a strobe on `mrs_strobe` starts no window and no `done` pulse.
- R8: If a strobe is sampled at clock edge E, the select window first shows on `dq_sel` after edge E+S, where S is `start_dly` at the strobe. S=0 drives right after edge E.
- R9: The window lasts H+1 cycles, where H is `hold_dly` at the strobe, so 0xFF gives the longest window of 256 cycles. In the cycle after the window, `dq_sel` is all 1s and `done` is 1 for exactly one cycle.
- R10: A strobe that arrives while a window is pending or active (`busy`=1) is ignored. It does not extend or restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Function enable; when clear, strobes are ignored |
| x8_mode | input | 1 | Device width: 0 = x4 (one nibble per device), 1 = x8 (two nibbles) |
| wr_en | input | 1 | Single-device enable write |
| wr_idx | input | 5 | Device index for the write |
| wr_val | input | 1 | Enable value written (0 = select) |
| bulk_en | input | 1 | Write `bulk_val` to every enable |
| bulk_val | input | 1 | Value for bulk write |
| start_dly | input | 8 | Cycles from strobe to select drive |
| hold_dly | input | 8 | Window length minus one |
| mrs_strobe | input | 1 | MRS issued by the command path |
| dq_sel | output | 18 | Per-nibble DQ level, 0 = driven low |
| busy | output | 1 | Window pending or active |
| done | output | 1 | One-cycle pulse after the window ends |
| idx_err | output | 1 | One-cycle flag for a rejected device index |

## Verification
A strobe sampled at edge E produces, in order, S cycles of all-ones after edges E..E+S-1, then H+1 cycles of the mask, then one all-ones cycle with `done` set. `idx_err` and any mask change show one edge after the write.

The driver task that raises the strobe pushes this whole per-cycle sequence into a queue. The monitor then pops one entry 1 ns after each rising edge, starting with edge E. Whenever the queue is empty, the monitor requires all-ones and no `done`. This is how ignored strobes and the disabled mode are checked against the exact cycles.

// File: rtl/dqsel_pkg.sv
package dqsel_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;
endpackage

// File: rtl/dqsel_mask.sv
module dqsel_mask #(
  parameter int NUM_NIBBLES  = 18,
  parameter int NIB_PER_WORD = 4,
  parameter int IDX_W        = $clog2(NUM_NIBBLES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   x8_mode,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_val,
  input  logic                   bulk_en,
  input  logic                   bulk_val,
  output logic [NUM_NIBBLES-1:0] mask_q,
  output logic                   err_q
);
  localparam int NUM_WORDS = (NUM_NIBBLES + NIB_PER_WORD - 1) / NIB_PER_WORD;
  localparam int DEV_X4    = NUM_NIBBLES;
  localparam int DEV_X8    = NUM_NIBBLES / 2;

  logic [NUM_NIBBLES-1:0] hit;
  logic                   in_range;

  assign in_range = x8_mode ? (wr_idx < IDX_W'(DEV_X8)) : (wr_idx < IDX_W'(DEV_X4));

  // Enables laid out word by word, four nibble lanes per word.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar l = 0; l < NIB_PER_WORD; l++) begin : g_lane
      localparam int N = w * NIB_PER_WORD + l;
      if (N < NUM_NIBBLES) begin : g_live
        assign hit[N] = x8_mode ? (wr_idx == IDX_W'(N / 2)) : (wr_idx == IDX_W'(N));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      err_q  <= 1'b0;
    end else begin
      err_q <= wr_en && !bulk_en && !in_range;
      if (bulk_en) begin
        mask_q <= {NUM_NIBBLES{bulk_val}};
      end else if (wr_en && in_range) begin
        for (int n = 0; n < NUM_NIBBLES; n++) begin
          if (hit[n]) mask_q[n] <= wr_val;
        end
      end
    end
  end

  // R5: a flagged write left the mask as it was
  p_err_mask_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (mask_q == $past(mask_q)));

  // R4: in x8 mode the two nibbles of a device always move together
  p_x8_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bulk_en && x8_mode && in_range) |=> (mask_q[2*$past(wr_idx)] == mask_q[2*$past(wr_idx)+1]));

  // R6: bulk write fills every enable
  p_bulk_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_en |=> (mask_q == {NUM_NIBBLES{$past(bulk_val)}}));
endmodule

// File: rtl/dqsel_timer.sv
module dqsel_timer
  import dqsel_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic             mrs_strobe,
  input  logic [DLY_W-1:0] start_dly,
  input  logic [DLY_W-1:0] hold_dly,
  output logic             active,
  output logic             busy,
  output logic             done_q
);
  phase_e           phase_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (mrs_strobe && mode_en) begin
            hold_q <= hold_dly;
            if (start_dly == '0) begin
              phase_q <= PH_HOLD;
              cnt_q   <= hold_dly;
            end else begin
              phase_q <= PH_WAIT;
              cnt_q   <= start_dly;
            end
          end
        end
        PH_WAIT: begin
          if (cnt_q == DLY_W'(1)) begin
            phase_q <= PH_HOLD;
            cnt_q   <= hold_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign active = (phase_q == PH_HOLD);
  assign busy   = (phase_q != PH_IDLE);

  // R7: disabled mode never starts a window
  p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mrs_strobe && !mode_en) |=> !busy);

  // R8: zero start delay drives right after the strobe edge
  p_zero_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mrs_strobe && mode_en && start_dly == '0) |=> active);

  // R9: done is a single-cycle pulse that follows the window
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_after_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(active));

  // R10: a strobe during a running window does not restart it
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q != '0 && mrs_strobe) |=> (active && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dram_dq_select.sv
module dram_dq_select #(
  parameter int NUM_NIBBLES  = 18,
  parameter int NIB_PER_WORD = 4,
  parameter int DLY_W        = 8,
  parameter int IDX_W        = $clog2(NUM_NIBBLES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_en,
  input  logic                   x8_mode,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_val,
  input  logic                   bulk_en,
  input  logic                   bulk_val,
  input  logic [DLY_W-1:0]       start_dly,
  input  logic [DLY_W-1:0]       hold_dly,
  input  logic                   mrs_strobe,
  output logic [NUM_NIBBLES-1:0] dq_sel,
  output logic                   busy,
  output logic                   done,
  output logic                   idx_err
);
  logic [NUM_NIBBLES-1:0] mask;
  logic                   active;

  dqsel_mask #(
    .NUM_NIBBLES (NUM_NIBBLES),
    .NIB_PER_WORD(NIB_PER_WORD),
    .IDX_W       (IDX_W)
  ) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .x8_mode (x8_mode),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_val  (wr_val),
    .bulk_en (bulk_en),
    .bulk_val(bulk_val),
    .mask_q  (mask),
    .err_q   (idx_err)
  );

  dqsel_timer #(
    .DLY_W(DLY_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .mrs_strobe(mrs_strobe),
    .start_dly (start_dly),
    .hold_dly  (hold_dly),
    .active    (active),
    .busy      (busy),
    .done_q    (done)
  );

  // Active-low select: idle level is high on every nibble.
  assign dq_sel = active ? mask : '1;

  // R2: outside the window all lanes stay high
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dq_sel == '1));

  // R9: the cycle of the done pulse shows idle level
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dq_sel == '1));
endmodule

// File: tb/dram_dq_select_tb.sv
`timescale 1ns/1ps
module dram_dq_select_tb;
  localparam int NN = 18;

  typedef struct {
    logic [NN-1:0] dq;
    logic          dn;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_en = 1'b1, x8_mode = 1'b0;
  logic          wr_en = 1'b0, wr_val = 1'b0, bulk_en = 1'b0, bulk_val = 1'b0;
  logic [4:0]    wr_idx = '0;
  logic [7:0]    start_dly = '0, hold_dly = '0;
  logic          mrs_strobe = 1'b0;
  logic [NN-1:0] dq_sel;
  logic          busy, done, idx_err;

  int   total = 0, bad = 0;
  bit   mon_on = 1'b0;
  exp_t q[$];
  logic [NN-1:0] m_exp = '1;

  always #2.5 clk = ~clk;

  dram_dq_select u_dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .x8_mode(x8_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .bulk_en(bulk_en),
    .bulk_val(bulk_val), .start_dly(start_dly), .hold_dly(hold_dly),
    .mrs_strobe(mrs_strobe), .dq_sel(dq_sel), .busy(busy), .done(done),
    .idx_err(idx_err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NN-1:0] act, input logic [NN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected entry per cycle, else requires idle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(dq_sel == e.dq, e.tag, "dq_sel", dq_sel, e.dq);
          check(done == e.dn, e.tag, "done", NN'(done), NN'(e.dn));
        end else begin
          check(dq_sel == '1 && done == 1'b0, "R2", "idle", {dq_sel[NN-2:0], done}, {{(NN-1){1'b1}}, 1'b0});
        end
      end
    end
  end

  task automatic run_mrs(input int s, input int h, input logic [NN-1:0] m, input string tag);
    @(negedge clk);
    start_dly  = 8'(s);
    hold_dly   = 8'(h);
    mrs_strobe = 1'b1;
    for (int i = 0; i < s; i++) q.push_back('{'1, 1'b0, tag});
    for (int i = 0; i <= h; i++) q.push_back('{m, 1'b0, tag});
    q.push_back('{'1, 1'b1, tag});
    @(negedge clk);
    mrs_strobe = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic wr(input int idx, input logic v, input bit exp_err, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_val = v;
    @(posedge clk);
    #1;
    check(idx_err == exp_err, tag, "idx_err", NN'(idx_err), NN'(exp_err));
    @(negedge clk);
    wr_en = 1'b0;
    if (!exp_err) begin
      if (x8_mode) begin
        m_exp[2*idx] = v; m_exp[2*idx+1] = v;
      end else begin
        m_exp[idx] = v;
      end
    end
  endtask

  task automatic bulk(input logic v);
    @(negedge clk);
    bulk_en = 1'b1; bulk_val = v;
    @(negedge clk);
    bulk_en = 1'b0;
    m_exp = {NN{v}};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dq_sel == '1, "R1", "dq_sel in reset", dq_sel, '1);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(dq_sel == '1 && !done && !idx_err, "R1", "after reset", {dq_sel[NN-3:0], done, idx_err}, {{(NN-2){1'b1}}, 2'b00});
    mon_on = 1'b1;

    // R1: reset mask deselects all devices
    run_mrs(0, 1, '1, "R1");
    drain();

    // R6, R8 immediate drive, R9 minimum hold
    bulk(1'b0);
    run_mrs(0, 0, m_exp, "R6");
    drain();

    // R3: x4 one nibble per device
    bulk(1'b1);
    wr(5, 1'b0, 1'b0, "R3");
    wr(17, 1'b0, 1'b0, "R3");
    run_mrs(3, 4, m_exp, "R3");
    drain();

    // R4: x8 pairs of nibbles
    x8_mode = 1'b1;
    bulk(1'b1);
    wr(2, 1'b0, 1'b0, "R4");
    wr(8, 1'b0, 1'b0, "R4");
    run_mrs(1, 2, m_exp, "R4");
    drain();

    // R5: out-of-range indices leave mask alone
    wr(9, 1'b1, 1'b1, "R5");
    x8_mode = 1'b0;
    wr(18, 1'b0, 1'b1, "R5");
    run_mrs(2, 1, m_exp, "R5");
    drain();

    // R6: bulk beats a same-cycle bad single write, no error
    @(negedge clk);
    bulk_en = 1'b1; bulk_val = 1'b0; wr_en = 1'b1; wr_idx = 5'd30; wr_val = 1'b1;
    @(posedge clk);
    #1;
    check(idx_err == 1'b0, "R6", "no err with bulk", NN'(idx_err), '0);
    @(negedge clk);
    bulk_en = 1'b0; wr_en = 1'b0;
    m_exp = '0;
    run_mrs(0, 2, m_exp, "R6");
    drain();

    // R7: disabled mode, monitor requires idle throughout
    mode_en = 1'b0;
    @(negedge clk); mrs_strobe = 1'b1;
    @(negedge clk); mrs_strobe = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    check(busy == 1'b0, "R7", "busy", NN'(busy), '0);
    mode_en = 1'b1;

    // R10: second strobe during the window is ignored
    bulk(1'b1);
    wr(0, 1'b0, 1'b0, "R10");
    run_mrs(2, 6, m_exp, "R10");
    repeat (3) @(negedge clk);
    mrs_strobe = 1'b1;
    @(negedge clk);
    mrs_strobe = 1'b0;
    drain();

    // R9: maximum hold of 256 cycles
    run_mrs(0, 255, m_exp, "R9");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule